// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the target side of a host bridge and decides whether an address arriving from the peripheral bus belongs to host memory. It holds three programmable inbound memory windows. Each window is a single register that combines a bus-side base address with a power-of-two size code. When a presented address falls inside a window, the block reports which window matched. It also reports the translated local address, which is the offset from the window base, since every window maps onto host memory starting at zero. A fourth register records the I/O window size in the same encoding. That register is held for software only and takes no part in decoding.

Configuration uses a simple 32-bit register port with a write strobe and a byte offset. Read data is returned one cycle after the offset is presented. A lookup is a single-cycle strobe carrying an address, and the registered result appears in the following cycle. The windows are tested in fixed priority, and a miss raises a dedicated no-hit flag.

Top module: `vwin_decoder`

## Requirements
- R1: During and right after synchronous reset, every window and the I/O size register hold zero (base 0, size code 0), `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_win` and `rsp_local` are zero, and `cfg_rdata` is zero.
- R2: A write stores bits 31:16 of `cfg_wdata` (bits 31:20 base, bits 19:16 size code) and discards bits 15:0. Reads return the stored bits in 31:16 and zero in 15:0, with the value on `cfg_rdata` one cycle after `cfg_addr` is presented. A write in the same cycle as a read of that offset shows the old value.
- R3: Offset 0x50 selects window 1, 0x54 window 2, 0x58 window 3 and 0x00 the I/O size register. Writes to any other offset change nothing, and reads of any other offset return zero.
- R4: An address hits a window when (address − base·2^20) modulo 2^32 is less than 2^(20+code). Code 0x0 means 1 MB and each step doubles the size, up to 0xB meaning 2 GB. A window set near the top of the space wraps around through zero.
- R5: On a hit, `rsp_local` equals (address − window base) modulo 2^32, because the local base is zero.
- R6: A window whose size code is 0xC to 0xF never hits.
- R7: When several windows hit, the lowest-numbered one is reported. `rsp_win` is 1, 2 or 3 for windows 1 to 3.
- R8: When no window hits, `rsp_miss` is 1, `rsp_hit` is 0, `rsp_win` is 0 and `rsp_local` is 0.
- R9: `rsp_valid` is `req_valid` delayed by one cycle. The lookup uses the register contents that existed before any write in the same cycle. When `rsp_valid` is 0, `rsp_hit`, `rsp_miss`, `rsp_win` and `rsp_local` are 0.
- R10: The contents of the I/O size register have no effect on any lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data for the previous cycle's offset |
| req_valid | input | 1 | Lookup strobe |
| req_addr | input | 32 | Bus-side address to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Address fell in a window |
| rsp_miss | output | 1 | Address fell in no window |
| rsp_win | output | 2 | Matching window number (1..3), 0 on miss |
| rsp_local | output | 32 | Translated local address, 0 on miss |

## Verification
The hardest situation to reach from the ports needs two things at once. Several enabled windows must overlap, so that priority matters. The address must also sit right at a window edge or wrap through zero at the top of the address space. Random addresses almost never land there. The stimulus therefore places windows on top of each other and near 0xFFF00000 and 0x80000000. It then draws most addresses as a window base plus or minus a small offset, or as the exact last byte inside a window. Writes are also issued in the same cycle as lookups and reads, to exercise the old-value ordering. Illegal size codes are mixed into the register writes.

// File: rtl/vwin_pkg.sv
package vwin_pkg;
  parameter int ADDR_W   = 32;
  parameter int BASE_W   = 12;
  parameter int CODE_W   = 4;
  parameter int NWIN     = 3;
  parameter int MAX_CODE = 11;
  parameter int CFG_AW   = 8;
  parameter int IO_OFF   = 'h00;
  parameter int WIN_OFF0 = 'h50;
  parameter int OFF_STEP = 4;

  localparam int SHIFT_LO = ADDR_W - BASE_W;
  localparam int FIELD_W  = BASE_W + CODE_W;
  localparam int IDX_W    = $clog2(NWIN + 1);

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [CODE_W-1:0] code;
  } win_cfg_t;
endpackage

// File: rtl/vwin_regs.sv
module vwin_regs
  import vwin_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [ADDR_W-1:0]          cfg_wdata,
  output logic [ADDR_W-1:0]          cfg_rdata,
  output win_cfg_t [NWIN-1:0]        win_cfg
);
  win_cfg_t io_cfg;
  win_cfg_t wr_field;
  win_cfg_t rd_field;

  assign wr_field = cfg_wdata[ADDR_W-1 -: FIELD_W];

  always_ff @(posedge clk) begin
    if (rst)
      io_cfg <= '0;
    else if (cfg_we && cfg_addr == CFG_AW'(IO_OFF))
      io_cfg <= wr_field;
  end

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam logic [CFG_AW-1:0] MY_OFF = CFG_AW'(WIN_OFF0 + OFF_STEP * i);
    always_ff @(posedge clk) begin
      if (rst)
        win_cfg[i] <= '0;
      else if (cfg_we && cfg_addr == MY_OFF)
        win_cfg[i] <= wr_field;
    end
  end

  always_comb begin
    rd_field = '0;
    if (cfg_addr == CFG_AW'(IO_OFF))
      rd_field = io_cfg;
    for (int i = 0; i < NWIN; i++)
      if (cfg_addr == CFG_AW'(WIN_OFF0 + OFF_STEP * i))
        rd_field = win_cfg[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= '0;
    else
      cfg_rdata <= {rd_field, {(ADDR_W-FIELD_W){1'b0}}};
  end
endmodule

// File: rtl/vwin_match.sv
module vwin_match
  import vwin_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  win_cfg_t          cfg,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  localparam int LW = ADDR_W + 1;

  logic [ADDR_W-1:0] base_full;
  logic [LW-1:0]     limit;
  logic              legal;

  assign base_full = {cfg.base, {SHIFT_LO{1'b0}}};
  assign offset    = addr - base_full;
  assign legal     = (cfg.code <= CODE_W'(MAX_CODE));
  assign limit     = LW'(1) << (SHIFT_LO + int'(cfg.code));
  assign hit       = legal && ({1'b0, offset} < limit);
endmodule

// File: rtl/vwin_decoder.sv
module vwin_decoder
  import vwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [1:0]        rsp_win,
  output logic [31:0]       rsp_local
);
  win_cfg_t [NWIN-1:0] win_cfg;
  logic [NWIN-1:0]     win_hit;
  logic [ADDR_W-1:0]   win_off [NWIN];

  logic                sel_hit;
  logic [IDX_W-1:0]    sel_idx;
  logic [ADDR_W-1:0]   sel_off;

  vwin_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .win_cfg   (win_cfg)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_match
    vwin_match u_match (
      .addr   (req_addr),
      .cfg    (win_cfg[i]),
      .hit    (win_hit[i]),
      .offset (win_off[i])
    );
  end

  // Scan from the top so the lowest-numbered hit is the last to land.
  always_comb begin
    sel_hit = 1'b0;
    sel_idx = '0;
    sel_off = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (win_hit[i]) begin
        sel_hit = 1'b1;
        sel_idx = IDX_W'(i + 1);
        sel_off = win_off[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_win   <= '0;
      rsp_local <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && sel_hit;
      rsp_miss  <= req_valid && !sel_hit;
      rsp_win   <= (req_valid && sel_hit) ? sel_idx : '0;
      rsp_local <= (req_valid && sel_hit) ? sel_off : '0;
    end
  end
endmodule

// File: rtl/vwin_decoder_chk.sv
module vwin_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] cfg_rdata,
  input logic        req_valid,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_miss,
  input logic [1:0]  rsp_win,
  input logic [31:0] rsp_local
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && rsp_win == 2'd0 && rsp_local == 32'd0));

  a_r8_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit != rsp_miss));

  a_r8_miss_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_miss |-> (rsp_win == 2'd0 && rsp_local == 32'd0));

  a_r7_win_on_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_win != 2'd0));

  a_r2_low_clear: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[15:0] == 16'd0);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && cfg_rdata == 32'd0));
endmodule

bind vwin_decoder vwin_decoder_chk u_chk (.*);

// File: tb/tb_vwin_decoder.sv
module tb_vwin_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = 32'd0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [1:0]  rsp_win;
  logic [31:0] rsp_local;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;

  always #4 clk = ~clk;

  vwin_decoder dut (.*);

  // Behavioural reference: index 0 = I/O size, 1..3 = windows
  logic [31:0] mr [4];
  logic [31:0] e_rdata, e_local;
  logic        e_valid, e_hit, e_miss;
  logic [1:0]  e_win;

  function automatic int off_idx(logic [7:0] a);
    case (a)
      8'h00: return 0;
      8'h50: return 1;
      8'h54: return 2;
      8'h58: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mr[k]) mr[k] = 32'd0;
      e_rdata = 0; e_valid = 0; e_hit = 0; e_miss = 0; e_win = 0; e_local = 0;
    end else begin
      int ix;
      ix = off_idx(cfg_addr);
      e_rdata = (ix < 0) ? 32'd0 : mr[ix];
      e_valid = req_valid; e_hit = 0; e_miss = req_valid; e_win = 0; e_local = 0;
      if (req_valid) begin
        for (int w = 3; w >= 1; w--) begin
          longint unsigned base, diff, code;
          base = longint'(mr[w][31:20]) * 64'd1048576;
          code = longint'(mr[w][19:16]);
          diff = (longint'(req_addr) + 64'h1_0000_0000 - base) % 64'h1_0000_0000;
          if (code <= 11 && diff < (64'd1 << (20 + code))) begin
            e_hit = 1; e_miss = 0; e_win = 2'(w); e_local = 32'(diff);
          end
        end
      end
      if (cfg_we && ix >= 0) mr[ix] = cfg_wdata & 32'hFFFF_0000;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R9 rsp_valid", 32'(rsp_valid), 32'(e_valid));
      chk("R4 rsp_hit", 32'(rsp_hit), 32'(e_hit));
      chk("R8 rsp_miss", 32'(rsp_miss), 32'(e_miss));
      chk("R7 rsp_win", 32'(rsp_win), 32'(e_win));
      chk("R5 rsp_local", rsp_local, e_local);
      chk("R2 cfg_rdata", cfg_rdata, e_rdata);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; req_valid = 0;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    cfg_addr = a; req_valid = 0;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic look_chk(logic [31:0] a, bit h, logic [1:0] w, logic [31:0] l, string tag);
    @(negedge clk);
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(tag, {rsp_hit, rsp_miss, rsp_win}, {h, !h, w});
    chk(tag, rsp_local, l);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 outputs", {rsp_hit, rsp_miss, rsp_win}, 0);
    chk("R1 cfg_rdata", cfg_rdata, 0);
    rst = 0;
    cmp_en = 1;
    rd_chk(8'h50, 32'd0, "R1 window reset value");

    // R2: low bits dropped on write and read as zero
    wr(8'h50, 32'h1000_ABCD);
    rd_chk(8'h50, 32'h1000_0000, "R2 truncated readback");
    // R4 / R5 / R8: 1 MB window edges
    look_chk(32'h100F_FFFF, 1, 2'd1, 32'h000F_FFFF, "R4 last byte of window 1");
    look_chk(32'h1010_0000, 0, 2'd0, 32'd0, "R8 just past window 1");
    look_chk(32'h0FFF_FFFF, 0, 2'd0, 32'd0, "R8 just below window 1");
    // R7: overlapping 8 MB window 2
    wr(8'h54, 32'h1003_0000);
    look_chk(32'h1000_0010, 1, 2'd1, 32'h0000_0010, "R7 window 1 wins overlap");
    look_chk(32'h1020_0000, 1, 2'd2, 32'h0020_0000, "R5 window 2 offset");
    // R6: illegal code never hits
    wr(8'h58, 32'h200C_0000);
    look_chk(32'h2000_0000, 0, 2'd0, 32'd0, "R6 illegal size code");
    wr(8'h58, 32'h200F_0000);
    look_chk(32'h2000_0004, 0, 2'd0, 32'd0, "R6 code 0xF");
    // R10: I/O size register stored but not decoded
    wr(8'h00, 32'h300B_1234);
    look_chk(32'h3000_0000, 0, 2'd0, 32'd0, "R10 io register no decode");
    rd_chk(8'h00, 32'h300B_0000, "R10 io readback");
    // R3: unmapped offset
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'd0, "R3 unmapped read zero");
    rd_chk(8'h54, 32'h1003_0000, "R3 unmapped write left window 2");
    // R4: 2 GB window and wraparound
    wr(8'h58, 32'h800B_0000);
    look_chk(32'hFFFF_FFFF, 1, 2'd3, 32'h7FFF_FFFF, "R4 top of 2 GB window");
    wr(8'h58, 32'hFFF1_0000);
    look_chk(32'h0005_0000, 1, 2'd3, 32'h0015_0000, "R4 wrap through zero");
    look_chk(32'h0010_0000, 0, 2'd0, 32'd0, "R4 wrap edge miss");

    // R9: random traffic, writes colliding with lookups and reads
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      begin
        int sel, w;
        logic [31:0] base;
        sel = $urandom % 6;
        cfg_we = ($urandom % 5) == 0;
        case ($urandom % 6)
          0: cfg_addr = 8'h00;
          1: cfg_addr = 8'h50;
          2: cfg_addr = 8'h54;
          3: cfg_addr = 8'h58;
          4: cfg_addr = 8'h4C;
          default: cfg_addr = 8'($urandom);
        endcase
        cfg_wdata = $urandom;
        if (($urandom % 4) == 0)
          cfg_wdata[31:20] = 12'hFFF - 12'($urandom % 4);
        if (($urandom % 3) != 0)
          cfg_wdata[19:16] = 4'($urandom % 12);
        req_valid = ($urandom % 4) != 0;
        w = 1 + ($urandom % 3);
        base = {mr[w][31:20], 20'd0};
        case (sel)
          0: req_addr = $urandom;
          1: req_addr = base + 32'($urandom % 64) - 32;
          2: req_addr = base + (32'd1 << (20 + (mr[w][19:16] % 12))) - 1;
          3: req_addr = base + (32'd1 << (20 + (mr[w][19:16] % 12)));
          default: req_addr = base + ($urandom & 32'h00FF_FFFF);
        endcase
      end
    end
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule